// File: doc/BRIEF.md
# Pipeline Front-End Stall and Flush Controller

This block sequences the front end of a five-stage in-order pipeline. It holds the program counter, the fetch-to-decode register (valid bit, instruction word, instruction address) and the control half of the decode-to-execute register (valid bit, register-write enable, memory read and write enables, destination register). On each clock edge every one of these registers either advances, holds or loads a bubble.

Two requests drive the block. A load-use request comes from an external comparator. The block accepts it only when its own execute-stage control shows a valid load whose destination is not register zero. An accepted request freezes the program counter and the fetch-to-decode register, and sends a bubble into execute, so the dependent instruction enters execute one cycle later and picks up the load data by forwarding. A taken-branch indication from execute comes with a target address. It loads the target into the program counter and bubbles both pipeline registers. It always overrides a load-use request that arrives in the same cycle.

Top module: `pipe_front_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the program counter to zero. It also makes both pipeline registers bubbles: valid bits cleared, all enables cleared, instruction word set to the NOP value 0x00000013.
- R2: With no accepted request and no taken branch, the program counter advances by 4 on each edge. The fetch-to-decode register captures valid=1, the fetched word and the current program counter. The execute control register captures the decode-stage controls, each gated by the fetch-to-decode valid bit.
- R3: An accepted load-use request holds the program counter and the fetch-to-decode register unchanged on the same edge that loads a bubble into the execute control register.
- R4: A load-use request is accepted only when the execute control register holds valid=1, memory-read=1 and a non-zero destination register. Otherwise it has no effect and the pipeline advances as in R2.
- R5: An accepted load-use stall lasts exactly one cycle. On the next edge the held instruction advances into execute, even if the request input stays high.
- R6: A taken branch loads the branch target into the program counter and bubbles both pipeline registers. The execute register therefore sees two bubble cycles in a row.
- R7: When a taken branch and a load-use request are present in the same cycle, the branch wins: the target is loaded and the fetch-to-decode register is bubbled, not held.
- R8: A bubble in the execute control register has its register-write, memory-read and memory-write enables all at zero.
- R9: Program counter arithmetic wraps modulo 2 to the power of the address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | IW | Instruction word fetched at the current program counter |
| luse_req | input | 1 | Load-use request from the hazard comparator |
| br_taken | input | 1 | Branch resolved taken in execute |
| br_target | input | AW | Branch target address |
| dec_reg_we | input | 1 | Decoded register-write enable of the instruction in decode |
| dec_mem_rd | input | 1 | Decoded memory-read (load) enable |
| dec_mem_wr | input | 1 | Decoded memory-write enable |
| dec_rd | input | RW | Decoded destination register |
| pc | output | AW | Program counter |
| fd_valid | output | 1 | Fetch-to-decode valid bit |
| fd_instr | output | IW | Fetch-to-decode instruction word |
| fd_pc | output | AW | Fetch-to-decode instruction address |
| dx_valid | output | 1 | Execute control valid bit |
| dx_reg_we | output | 1 | Execute register-write enable |
| dx_mem_rd | output | 1 | Execute memory-read enable |
| dx_mem_wr | output | 1 | Execute memory-write enable |
| dx_rd | output | RW | Execute destination register |

## Verification
The bench builds the block with a 12-bit address width and keeps the default 32-bit instruction and 5-bit register widths. The narrow address lets a branch to 0xFFC followed by one normal advance show the wrap to zero of R9 within a few cycles. The narrow address does not shorten the load-use and branch traces. Those traces are compared cycle by cycle against values worked out from the requirements.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_FLUSH = 2'd2
  } stage_act_e;
endpackage

// File: rtl/pfc_pc_reg.sv
module pfc_pc_reg
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  stage_act_e    act,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q
);
  localparam logic [AW-1:0] STEP = AW'(IW / 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      unique case (act)
        ACT_FLUSH: pc_q <= target;
        ACT_HOLD:  pc_q <= pc_q;
        default:   pc_q <= pc_q + STEP;
      endcase
    end
  end

  a_r9_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_RUN) |=> (pc_q == AW'($past(pc_q) + STEP)));
endmodule

// File: rtl/pfc_fd_reg.sv
module pfc_fd_reg
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter logic [IW-1:0] NOP_WORD = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst,
  input  stage_act_e    act,
  input  logic [IW-1:0] word_in,
  input  logic [AW-1:0] pc_in,
  output logic          valid_q,
  output logic [IW-1:0] instr_q,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst || act == ACT_FLUSH) begin
      valid_q <= 1'b0;
      instr_q <= NOP_WORD;
      pc_q    <= '0;
    end else if (act == ACT_RUN) begin
      valid_q <= 1'b1;
      instr_q <= word_in;
      pc_q    <= pc_in;
    end
  end

  a_r3_fd_held: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> ($stable(instr_q) && $stable(pc_q) && $stable(valid_q)));

  a_r6_fd_bubbled: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_FLUSH) |=> (!valid_q && instr_q == NOP_WORD));
endmodule

// File: rtl/pfc_dx_reg.sv
module pfc_dx_reg
  import pfc_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  stage_act_e    act,
  input  logic          src_valid,
  input  logic          reg_we_in,
  input  logic          mem_rd_in,
  input  logic          mem_wr_in,
  input  logic [RW-1:0] rd_in,
  output logic          valid_q,
  output logic          reg_we_q,
  output logic          mem_rd_q,
  output logic          mem_wr_q,
  output logic [RW-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst || act != ACT_RUN) begin
      valid_q  <= 1'b0;
      reg_we_q <= 1'b0;
      mem_rd_q <= 1'b0;
      mem_wr_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      valid_q  <= src_valid;
      reg_we_q <= reg_we_in & src_valid;
      mem_rd_q <= mem_rd_in & src_valid;
      mem_wr_q <= mem_wr_in & src_valid;
      rd_q     <= src_valid ? rd_in : '0;
    end
  end

  a_r8_bubble_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!reg_we_q && !mem_rd_q && !mem_wr_q));
endmodule

// File: rtl/pipe_front_ctrl.sv
module pipe_front_ctrl
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int RW = 5,
  parameter logic [IW-1:0] NOP_WORD = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] fetch_word,
  input  logic          luse_req,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          dec_reg_we,
  input  logic          dec_mem_rd,
  input  logic          dec_mem_wr,
  input  logic [RW-1:0] dec_rd,
  output logic [AW-1:0] pc,
  output logic          fd_valid,
  output logic [IW-1:0] fd_instr,
  output logic [AW-1:0] fd_pc,
  output logic          dx_valid,
  output logic          dx_reg_we,
  output logic          dx_mem_rd,
  output logic          dx_mem_wr,
  output logic [RW-1:0] dx_rd
);
  logic       stall_ok;
  stage_act_e front_act;
  stage_act_e back_act;

  // A request counts only against a real load that writes a real register.
  assign stall_ok = luse_req && dx_valid && dx_mem_rd && (dx_rd != '0);

  // Branch flush takes precedence over the load-use freeze.
  always_comb begin
    if (br_taken) begin
      front_act = ACT_FLUSH;
      back_act  = ACT_FLUSH;
    end else if (stall_ok) begin
      front_act = ACT_HOLD;
      back_act  = ACT_FLUSH;
    end else begin
      front_act = ACT_RUN;
      back_act  = ACT_RUN;
    end
  end

  pfc_pc_reg #(.AW(AW), .IW(IW)) u_pc (
    .clk(clk), .rst(rst), .act(front_act), .target(br_target), .pc_q(pc)
  );

  pfc_fd_reg #(.AW(AW), .IW(IW), .NOP_WORD(NOP_WORD)) u_fd (
    .clk(clk), .rst(rst), .act(front_act), .word_in(fetch_word), .pc_in(pc),
    .valid_q(fd_valid), .instr_q(fd_instr), .pc_q(fd_pc)
  );

  pfc_dx_reg #(.RW(RW)) u_dx (
    .clk(clk), .rst(rst), .act(back_act), .src_valid(fd_valid),
    .reg_we_in(dec_reg_we), .mem_rd_in(dec_mem_rd), .mem_wr_in(dec_mem_wr),
    .rd_in(dec_rd), .valid_q(dx_valid), .reg_we_q(dx_reg_we),
    .mem_rd_q(dx_mem_rd), .mem_wr_q(dx_mem_wr), .rd_q(dx_rd)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0 && !fd_valid && !dx_valid && fd_instr == NOP_WORD));

  a_r3_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    (stall_ok && !br_taken) |=> (pc == $past(pc) && !dx_valid));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (stall_ok && !br_taken) |=> !stall_ok);

  a_r7_branch_wins: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(br_target) && !fd_valid && !dx_valid));
endmodule

// File: tb/pipe_front_ctrl_bench.sv
module pipe_front_ctrl_bench;
  localparam int AW = 12;
  localparam int IW = 32;
  localparam int RW = 5;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic          clk = 1'b0;
  logic          rst;
  logic [IW-1:0] fetch_word;
  logic          luse_req, br_taken;
  logic [AW-1:0] br_target;
  logic          dec_reg_we, dec_mem_rd, dec_mem_wr;
  logic [RW-1:0] dec_rd;
  logic [AW-1:0] pc, fd_pc;
  logic          fd_valid, dx_valid, dx_reg_we, dx_mem_rd, dx_mem_wr;
  logic [IW-1:0] fd_instr;
  logic [RW-1:0] dx_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipe_front_ctrl #(.AW(AW), .IW(IW), .RW(RW)) u_pipe_front_ctrl (
    .clk(clk), .rst(rst), .fetch_word(fetch_word), .luse_req(luse_req),
    .br_taken(br_taken), .br_target(br_target), .dec_reg_we(dec_reg_we),
    .dec_mem_rd(dec_mem_rd), .dec_mem_wr(dec_mem_wr), .dec_rd(dec_rd),
    .pc(pc), .fd_valid(fd_valid), .fd_instr(fd_instr), .fd_pc(fd_pc),
    .dx_valid(dx_valid), .dx_reg_we(dx_reg_we), .dx_mem_rd(dx_mem_rd),
    .dx_mem_wr(dx_mem_wr), .dx_rd(dx_rd)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic dec(logic we, logic mr, logic mw, logic [RW-1:0] rd);
    dec_reg_we = we; dec_mem_rd = mr; dec_mem_wr = mw; dec_rd = rd;
  endtask

  task automatic chk_front(string req, logic [AW-1:0] epc, logic ev,
                           logic [IW-1:0] ei, logic [AW-1:0] efp);
    chk(req, "pc", 64'(pc), 64'(epc));
    chk(req, "fd_valid", 64'(fd_valid), 64'(ev));
    chk(req, "fd_instr", 64'(fd_instr), 64'(ei));
    chk(req, "fd_pc", 64'(fd_pc), 64'(efp));
  endtask

  task automatic chk_dx(string req, logic v, logic we, logic mr, logic mw, logic [RW-1:0] rd);
    chk(req, "dx_valid", 64'(dx_valid), 64'(v));
    chk(req, "dx_reg_we", 64'(dx_reg_we), 64'(we));
    chk(req, "dx_mem_rd", 64'(dx_mem_rd), 64'(mr));
    chk(req, "dx_mem_wr", 64'(dx_mem_wr), 64'(mw));
    chk(req, "dx_rd", 64'(dx_rd), 64'(rd));
  endtask

  task automatic do_reset();
    rst = 1; luse_req = 0; br_taken = 0; br_target = '0;
    fetch_word = 32'hAAAA_0001; dec(1, 1, 1, 5'd9);
    step(); step();
    rst = 0;
    chk_front("R1", 0, 0, NOP, 0);
    chk_dx("R1", 0, 0, 0, 0, 0);
  endtask

  // Load then dependent use, back to back: one stall cycle.
  task automatic t_load_use();
    do_reset();
    fetch_word = 32'h1000_0003; dec(0, 0, 0, 0); step();
    chk_front("R2", 12'h004, 1, 32'h1000_0003, 12'h000);
    chk_dx("R2", 0, 0, 0, 0, 0);
    dec(1, 1, 0, 5'd5); fetch_word = 32'h2000_0033; step();
    chk_front("R2", 12'h008, 1, 32'h2000_0033, 12'h004);
    chk_dx("R2", 1, 1, 1, 0, 5'd5);
    luse_req = 1; dec(1, 0, 0, 5'd6); fetch_word = 32'h3000_0013; step();
    chk_front("R3", 12'h008, 1, 32'h2000_0033, 12'h004);
    chk_dx("R3", 0, 0, 0, 0, 0);
    step();
    chk_front("R5", 12'h00C, 1, 32'h3000_0013, 12'h008);
    chk_dx("R5", 1, 1, 0, 0, 5'd6);
    luse_req = 0;
  endtask

  // One independent instruction between load and use: no stall.
  task automatic t_separated();
    do_reset();
    fetch_word = 32'h1100_0003; dec(0, 0, 0, 0); step();
    dec(1, 1, 0, 5'd7); fetch_word = 32'h1200_0033; step();
    dec(1, 0, 0, 5'd8); fetch_word = 32'h1300_0033; step();
    chk_front("R2", 12'h00C, 1, 32'h1300_0033, 12'h008);
    chk_dx("R2", 1, 1, 0, 0, 5'd8);
    // request while EX holds a non-load: ignored
    luse_req = 1; dec(1, 0, 1, 5'd9); step();
    chk_front("R4", 12'h010, 1, 32'h1300_0033, 12'h00C);
    chk_dx("R4", 1, 1, 0, 1, 5'd9);
    luse_req = 0;
  endtask

  // Load to register zero: request ignored.
  task automatic t_zero_dest();
    do_reset();
    fetch_word = 32'h1400_0003; dec(0, 0, 0, 0); step();
    dec(0, 1, 0, 5'd0); step();
    chk_dx("R4", 1, 0, 1, 0, 5'd0);
    luse_req = 1; dec(1, 0, 0, 5'd3); fetch_word = 32'h1500_0033; step();
    chk_front("R4", 12'h00C, 1, 32'h1500_0033, 12'h008);
    chk_dx("R4", 1, 1, 0, 0, 5'd3);
    luse_req = 0;
  endtask

  // Taken branch in the same cycle as an accepted stall.
  task automatic t_branch_stall();
    do_reset();
    fetch_word = 32'h1600_0003; dec(0, 0, 0, 0); step();
    dec(1, 1, 0, 5'd4); step();
    chk_dx("R7", 1, 1, 1, 0, 5'd4);
    luse_req = 1; br_taken = 1; br_target = 12'h200; dec(1, 0, 0, 5'd2); step();
    chk_front("R7", 12'h200, 0, NOP, 12'h000);
    chk_dx("R7", 0, 0, 0, 0, 0);
    luse_req = 0; br_taken = 0; fetch_word = 32'h1700_0033; step();
    chk_front("R6", 12'h204, 1, 32'h1700_0033, 12'h200);
    chk_dx("R6", 0, 0, 0, 0, 0);
    chk_dx("R8", 0, 0, 0, 0, 0);
  endtask

  // Branch near top of address space, then wrap.
  task automatic t_wrap();
    do_reset();
    br_taken = 1; br_target = 12'hFFC; step();
    chk("R6", "pc", 64'(pc), 64'h0FFC);
    br_taken = 0; fetch_word = 32'h1800_0013; step();
    chk_front("R9", 12'h000, 1, 32'h1800_0013, 12'hFFC);
  endtask

  initial begin
    t_load_use();
    t_separated();
    t_zero_dest();
    t_branch_stall();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule